// File: doc/BRIEF.md
# Shared-Line Interrupt Distributor

This block gathers 32 level-sensitive interrupt lines from peripherals and presents them to a single processor on two wires. `irq` is the normal request and `fiq` is the fast request. Each line has its own enable, pending, active and group bits and an 8-bit priority byte. The line's group bit chooses which output the line drives, and each output has its own group enable. A line counts as eligible only when it is pending, enabled and not active.

Software programs the block over a small word-addressed register bus. Writes take effect on the clock edge. Reads are combinational.

The processor takes an interrupt through the acknowledge port. The acknowledge returns the lowest-numbered pending line plus 32, or 1023 when no line is pending, and the acknowledged line becomes active. The processor later releases the line through the end-of-interrupt port. Priorities are stored and read back but take no part in the choice of line.

Top module: `irq_dist`

## Requirements
- R1: A line event with `line_idx` of 32 or more changes no state: the outputs, `ack_id` and all register reads are unchanged.
- R2: A line is eligible when it is pending, enabled and not active. When no line is eligible, both `irq` and `fiq` are 0.
- R3: `irq` is 1 when an eligible line has group bit 1 and group-1 forwarding is enabled. `fiq` is 1 when an eligible line has group bit 0 and group-0 forwarding is enabled.
- R4: The control register is at word address 0. Bit 0 is the group-0 enable and bit 1 is the group-1 enable. A read returns those two bits, with bits 31:2 zero.
- R5: Writing word address 1 ORs the written data into the enable mask. Writing word address 2 clears every enable bit that is 1 in the written data. Reads of address 1 and of address 2 both return the enable mask.
- R6: Writing word address 3 ORs the written data into the group mask, so a group bit that is 1 stays 1 until reset. A read of address 3 returns the group mask.
- R7: Writing word address 4 clears every active bit that is 1 in the written data. The outputs are then re-evaluated.
- R8: Word addresses 8 to 15 hold the priorities. Word 8+k holds the bytes of lines 4k to 4k+3, with the lowest-numbered line in bits 7:0. Reads return the bytes in the same order. Unmapped addresses read 0.
- R9: `ack_id` is the lowest-numbered pending line plus 32, or 1023 when no line is pending. It ignores enable, active and priority. A clock edge with `ack_req` high sets the active bit of that line.
- R10: A line event with level 1 sets the line's pending bit, and a line event with level 0 clears it.
- R11: An end-of-interrupt with an ID from 32 to 63 clears the active bit of line ID−32. Any other ID has no effect.
- R12: After reset, all masks, priorities and both group enables are 0, and `irq` and `fiq` are 0. State changes on the edge where a request is sampled, and `irq` and `fiq` follow on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| line_valid | input | 1 | Line event strobe |
| line_idx | input | 6 | Line number of the event |
| line_level | input | 1 | New level of the line |
| ack_req | input | 1 | Acknowledge request |
| ack_id | output | 10 | Acknowledge result ID |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being retired |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench sweeps every line through both levels under a mixed group pattern. It checks the routing and the acknowledge ID for each line, so a design that used the wrong group polarity, lost a line index or returned the highest line instead of the lowest is caught. It also drives line indices 32 to 63 and retires out-of-range IDs, catching a design that truncated the index and aliased these onto real lines. Active masking is tested by acknowledging one of several pending lines. The active bit is then released first through the register bus and then through end-of-interrupt, so a design that kept the output high while the line was active, or never cleared the active bit, is exposed. All 8 priority words are written and read back, which exposes byte swaps or word aliasing. The sticky group write is checked as well, exposing any design that cleared group bits on a write.

// File: rtl/irq_dist.sv
module irq_dist #(
  parameter int NLINES  = 32,
  parameter int IDW     = 10,
  parameter int ID_BASE = 32,
  parameter int ID_NONE = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              line_valid,
  input  logic [5:0]        line_idx,
  input  logic              line_level,
  input  logic              ack_req,
  output logic [IDW-1:0]    ack_id,
  input  logic              eoi_valid,
  input  logic [IDW-1:0]    eoi_id,
  output logic              irq,
  output logic              fiq
);
  localparam int LW = $clog2(NLINES);

  logic [NLINES-1:0] en_q, pend_q, act_q, grp_q;
  logic              g0_q, g1_q;
  logic [7:0]        prio_q [NLINES];

  logic [NLINES-1:0] fwd, ack_mask, eoi_mask, actclr_mask;
  logic [LW-1:0]     first_idx;
  logic              any_pend;
  logic [IDW-1:0]    eoi_off;

  assign fwd = pend_q & en_q & ~act_q;

  always_comb begin
    first_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pend_q[i]) first_idx = i[LW-1:0];
  end
  assign any_pend = |pend_q;
  assign ack_id   = any_pend ? IDW'(ID_BASE) + IDW'(first_idx) : IDW'(ID_NONE);
  assign ack_mask = (ack_req && any_pend) ? (NLINES'(1) << first_idx) : '0;

  assign eoi_off  = eoi_id - IDW'(ID_BASE);
  assign eoi_mask = (eoi_valid && eoi_id >= IDW'(ID_BASE) && eoi_id < IDW'(ID_BASE + NLINES))
                    ? (NLINES'(1) << eoi_off[LW-1:0]) : '0;
  assign actclr_mask = (bus_we && bus_addr == 4'd4) ? bus_wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
      g0_q   <= 1'b0;
      g1_q   <= 1'b0;
      irq    <= 1'b0;
      fiq    <= 1'b0;
      for (int i = 0; i < NLINES; i++) prio_q[i] <= '0;
    end else begin
      irq <= g1_q && |(fwd & grp_q);
      fiq <= g0_q && |(fwd & ~grp_q);
      act_q <= (act_q & ~actclr_mask & ~eoi_mask) | ack_mask;
      if (line_valid && line_idx < 6'(NLINES))
        pend_q[line_idx[LW-1:0]] <= line_level;
      if (bus_we) begin
        case (bus_addr)
          4'd0: begin g0_q <= bus_wdata[0]; g1_q <= bus_wdata[1]; end
          4'd1: en_q  <= en_q | bus_wdata[NLINES-1:0];
          4'd2: en_q  <= en_q & ~bus_wdata[NLINES-1:0];
          4'd3: grp_q <= grp_q | bus_wdata[NLINES-1:0];
          default: ;
        endcase
        if (bus_addr[3])
          for (int b = 0; b < 4; b++)
            prio_q[{bus_addr[2:0], b[1:0]}] <= bus_wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      4'd0:       bus_rdata = {30'd0, g1_q, g0_q};
      4'd1, 4'd2: bus_rdata = en_q;
      4'd3:       bus_rdata = grp_q;
      default:
        if (bus_addr[3])
          bus_rdata = {prio_q[{bus_addr[2:0], 2'd3}], prio_q[{bus_addr[2:0], 2'd2}],
                       prio_q[{bus_addr[2:0], 2'd1}], prio_q[{bus_addr[2:0], 2'd0}]};
    endcase
  end

  a_r1_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_idx >= 6'(NLINES)) |=> $stable(pend_q));
  a_r2_idle_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd == '0) |=> (!irq && !fiq));
  a_r4_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'd0) |-> (bus_rdata[31:2] == '0));
  a_r6_group_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) or 1'b1 |=> ((grp_q & $past(grp_q)) == $past(grp_q)));
  a_r9_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_id != IDW'(ID_NONE)) |=> act_q[$past(first_idx)]);
  a_r9_ack_none_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (ack_id == IDW'(ID_NONE)));
endmodule

// File: tb/irq_dist_test.sv
module irq_dist_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0; logic [3:0] bus_addr = 0; logic [31:0] bus_wdata = 0; logic [31:0] bus_rdata;
  logic line_valid = 0; logic [5:0] line_idx = 0; logic line_level = 0;
  logic ack_req = 0; logic [9:0] ack_id;
  logic eoi_valid = 0; logic [9:0] eoi_id = 0;
  logic irq, fiq;

  irq_dist uut (.clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
                .line_valid, .line_idx, .line_level, .ack_req, .ack_id,
                .eoi_valid, .eoi_id, .irq, .fiq);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, bad = 0;
  logic [31:0] m_en = 0, m_pend = 0, m_act = 0, m_grp = 0;
  logic m_g0 = 0, m_g1 = 0;

  task automatic ck(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] exp_ack();
    for (int i = 0; i < 32; i++) if (m_pend[i]) return 10'(i + 32);
    return 10'd1023;
  endfunction

  task automatic chk_out(string tag);
    logic [31:0] f;
    @(posedge clk); @(negedge clk);
    f = m_pend & m_en & ~m_act;
    ck({tag, " irq"}, 32'(irq), 32'(m_g1 && |(f & m_grp)));
    ck({tag, " fiq"}, 32'(fiq), 32'(m_g0 && |(f & ~m_grp)));
    ck({tag, " ack_id"}, 32'(ack_id), 32'(exp_ack()));
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
    case (a)
      4'd0: begin m_g0 = d[0]; m_g1 = d[1]; end
      4'd1: m_en = m_en | d;
      4'd2: m_en = m_en & ~d;
      4'd3: m_grp = m_grp | d;
      4'd4: m_act = m_act & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    ck(tag, bus_rdata, exp);
  endtask

  task automatic setl(int idx, logic lvl);
    line_valid = 1; line_idx = 6'(idx); line_level = lvl;
    @(posedge clk); @(negedge clk);
    line_valid = 0;
    if (idx < 32) m_pend[idx] = lvl;
  endtask

  task automatic do_ack(string tag);
    logic [9:0] e;
    ack_req = 1; #1;
    e = exp_ack();
    ck(tag, 32'(ack_id), 32'(e));
    @(posedge clk); @(negedge clk);
    ack_req = 0;
    if (e != 10'd1023) m_act[e - 10'd32] = 1'b1;
  endtask

  task automatic do_eoi(logic [9:0] id);
    eoi_valid = 1; eoi_id = id;
    @(posedge clk); @(negedge clk);
    eoi_valid = 0;
    if (id >= 32 && id < 64) m_act[id - 10'd32] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    ck("R12 irq after reset", 32'(irq), 0);
    ck("R12 fiq after reset", 32'(fiq), 0);
    ck("R12 ack_id after reset", 32'(ack_id), 1023);
    for (int a = 0; a < 16; a++) rd("R12 register reset", 4'(a), 0);

    // R4 control
    wr(4'd0, 32'hFFFF_FFFF); rd("R4 ctrl all ones", 4'd0, 32'h3);
    wr(4'd0, 32'h0000_0001); rd("R4 ctrl g0 only", 4'd0, 32'h1);
    wr(4'd0, 32'h3);

    // R5 enables
    wr(4'd1, 32'h0000_00F0); wr(4'd1, 32'h0000_0F00);
    wr(4'd2, 32'h0000_0330);
    rd("R5 set-enable readback", 4'd1, 32'h0000_0CC0);
    rd("R5 clear-enable readback", 4'd2, 32'h0000_0CC0);
    wr(4'd1, 32'hFFFF_FFFF);

    // R6 sticky group
    wr(4'd3, 32'hAAAA_AAAA); wr(4'd3, 32'h0);
    rd("R6 group not cleared", 4'd3, 32'hAAAA_AAAA);

    // R10 / R3 sweep of every line
    for (int i = 0; i < 32; i++) begin
      setl(i, 1'b1); chk_out("R10 R3 line set");
      setl(i, 1'b0); chk_out("R10 R2 line clear");
    end

    // R1 out-of-range indices
    for (int i = 32; i < 64; i++) begin
      setl(i, 1'b1); chk_out("R1 bad index ignored");
    end
    rd("R1 enable unchanged", 4'd1, 32'hFFFF_FFFF);

    // R3 group enable combinations with one line of each group
    setl(4, 1'b1); setl(7, 1'b1);
    for (int c = 0; c < 4; c++) begin
      wr(4'd0, 32'(c)); chk_out("R3 group enable combo");
    end
    wr(4'd0, 32'h3);
    wr(4'd2, 32'h0000_0090); chk_out("R2 disabled lines not forwarded");
    wr(4'd1, 32'h0000_0090); chk_out("R2 re-enabled");

    // R9 ack lowest, R2 active masking
    setl(2, 1'b1);
    do_ack("R9 ack lowest pending"); chk_out("R2 active line masked");
    do_ack("R9 ack ignores active"); chk_out("R9 after second ack");
    setl(2, 1'b0);
    do_ack("R9 next lowest"); chk_out("R2 two active");
    // R7 clear active via bus
    wr(4'd4, 32'h0000_0010); chk_out("R7 active cleared by bus");
    // R11 eoi
    do_ack("R9 ack again"); chk_out("R11 before eoi");
    do_eoi(10'd10); chk_out("R11 id below range ignored");
    do_eoi(10'd64); chk_out("R11 id above range ignored");
    do_eoi(10'd36); chk_out("R11 eoi clears line 4");
    do_eoi(10'd39); chk_out("R11 eoi clears line 7");
    setl(4, 1'b0); setl(7, 1'b0);
    do_ack("R9 none pending"); chk_out("R9 idle");

    // R8 priorities
    for (int w = 0; w < 8; w++)
      wr(4'(8 + w), {8'(4*w+3) ^ 8'h5A, 8'(4*w+2) ^ 8'hC3, 8'(4*w+1) ^ 8'h99, 8'(4*w) ^ 8'h11});
    for (int w = 0; w < 8; w++)
      rd("R8 priority word", 4'(8 + w),
         {8'(4*w+3) ^ 8'h5A, 8'(4*w+2) ^ 8'hC3, 8'(4*w+1) ^ 8'h99, 8'(4*w) ^ 8'h11});
    for (int a = 5; a < 8; a++) rd("R8 unmapped reads zero", 4'(a), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule